// File: doc/BRIEF.md
# Match-Compare System Timer

This block keeps a 32-bit up-counter that advances by one on every clock cycle in which the tick-enable input is high. Four compare channels each hold a 32-bit match value. When a tick moves the counter onto a channel's match value, the channel reports a match event. If that channel's interrupt-enable bit is set, the event sets its status bit, and the status bit drives that channel's interrupt line. Software clears status bits by writing ones to them.

The last compare channel can also serve as a watchdog. When software sets the arm bit and channel 3 then matches, the block pulses a system reset request for one cycle and clears the arm bit. All state is reached through a simple word-addressed write/read bus. Reads are combinational on the byte offset.

Top module: `match_timer`

## Requirements
- R1: After a synchronous active-low reset, the counter, all match values, status, interrupt enable and watchdog arm read as zero, and all interrupt lines and the reset request are low.
- R2: Writing offset 0x10 loads the counter. In every other cycle where tick_en is high, the counter increments by one. When tick_en is low and the counter is not written, the counter holds its value.
- R3: The match values for channels 0 to 3 are at offsets 0x00, 0x04, 0x08 and 0x0C. A tick that moves the counter onto channel n's match value sets status bit n (offset 0x14) and raises irq[n]. This happens only when interrupt-enable bit n (offset 0x1C) is set. Otherwise status and irq stay unchanged.
- R4: A write to offset 0x14 clears each status bit whose written bit is 1, and it drops the matching irq line. Bits written as 0 are unchanged. A new match in the same cycle takes precedence over the clear.
- R5: A match fires only on the tick that reaches the match value. Staying at that value, loading the counter directly to it, or writing the match register does not set status.
- R6: The interrupt-enable register keeps bits 11:0 of a write and reads back zero above them.
- R7: Offset 0x18 bit 0 is the watchdog arm bit; other written bits are dropped. When channel 3 matches while armed, rst_req is high for exactly one cycle and the arm bit clears. This happens regardless of interrupt enable. When the block is not armed, a channel 3 match causes no reset request.
- R8: Matching uses modulo-2^32 arithmetic. A counter loaded near 0xFFFFFFFF wraps through zero and matches small values.
- R9: Reads of unmapped offsets return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Counter advances by one in cycles where high |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 4 | Per-channel interrupt lines |
| rst_req | output | 1 | One-cycle system reset request from the watchdog |

## Verification
The hardest case to reach is the exact tick on which the counter steps onto a match value. This includes the step across the 32-bit wrap, which free counting would take billions of cycles to reach. The bench loads the counter a few counts before each chosen match value. It then runs a measured number of ticks and checks that the line is still low one tick early and high exactly on time. It sweeps every channel against several distances. The watchdog pulse is counted by a monitor, so that a stretched or repeated request shows up as a wrong count.

// File: rtl/match_timer_pkg.sv
// Shared constants for the match-compare timer: register byte offsets
// and bus widths. Assumes word-aligned 32-bit registers.
package match_timer_pkg;
    localparam int MT_DATA_W   = 32;
    localparam int MT_ADDR_W   = 8;
    localparam int MT_OFF_MATCH0 = 8'h00;
    localparam int MT_OFF_COUNT  = 8'h10;
    localparam int MT_OFF_STATUS = 8'h14;
    localparam int MT_OFF_WDOG   = 8'h18;
    localparam int MT_OFF_IEN    = 8'h1C;
endpackage

// File: rtl/mt_counter.sv
// Free-running up-counter with a load port. A load takes priority over a
// tick. 'step' marks cycles where the count advances by one, and 'cnt_nxt'
// is the value it advances to. Assumes synchronous active-low reset.
module mt_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nxt,
    output logic         step
);
    // Incremented value and advance qualifier.
    always_comb begin
        cnt_nxt = cnt_q + W'(1);
        step    = tick_en && !load;
    end

    // Counter register: reset, load, or advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (step)
            cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/mt_channel.sv
// One compare channel. It holds a match value and flags a hit when a
// counter step lands on that value. A direct load of the counter never
// produces a hit. Assumes synchronous active-low reset.
module mt_channel #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_match,
    input  logic [W-1:0] wdata,
    input  logic         step,
    input  logic [W-1:0] cnt_nxt,
    output logic [W-1:0] match_q,
    output logic         hit
);
    // Match value register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            match_q <= '0;
        else if (wr_match)
            match_q <= wdata;
    end

    // Hit only on the step that reaches the match value.
    always_comb hit = step && (cnt_nxt == match_q);
endmodule

// File: rtl/match_timer.sv
// Match-compare system timer top. It wires a shared counter to NUM_CH
// compare channels and holds the interrupt-enable, status (write-one-to-
// clear) and watchdog arm registers. The last channel doubles as the
// watchdog. Assumes one write per cycle and combinational reads.
module match_timer
    import match_timer_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int IEN_W  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic [MT_ADDR_W-1:0] bus_addr,
    input  logic                 bus_wr,
    input  logic [MT_DATA_W-1:0] bus_wdata,
    output logic [MT_DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0]    irq,
    output logic                 rst_req
);
    localparam int W     = MT_DATA_W;
    localparam int WD_CH = NUM_CH - 1;

    logic [W-1:0]      cnt_q, cnt_nxt;
    logic              step;
    logic              wr_count, wr_status, wr_wdog, wr_ien;
    logic [W-1:0]      match_q [NUM_CH];
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] status_q;
    logic [IEN_W-1:0]  ien_q;
    logic              wd_arm_q;

    // Decode of the fixed-offset write targets.
    always_comb begin
        wr_count  = bus_wr && (bus_addr == MT_ADDR_W'(MT_OFF_COUNT));
        wr_status = bus_wr && (bus_addr == MT_ADDR_W'(MT_OFF_STATUS));
        wr_wdog   = bus_wr && (bus_addr == MT_ADDR_W'(MT_OFF_WDOG));
        wr_ien    = bus_wr && (bus_addr == MT_ADDR_W'(MT_OFF_IEN));
    end

    mt_counter #(.W(W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .load     (wr_count),
        .load_val (bus_wdata),
        .cnt_q    (cnt_q),
        .cnt_nxt  (cnt_nxt),
        .step     (step)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic wr_match;
        // Per-channel match register write decode.
        always_comb wr_match = bus_wr &&
            (bus_addr == MT_ADDR_W'(MT_OFF_MATCH0 + 4 * i));

        mt_channel #(.W(W)) ch_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_match (wr_match),
            .wdata    (bus_wdata),
            .step     (step),
            .cnt_nxt  (cnt_nxt),
            .match_q  (match_q[i]),
            .hit      (hit[i])
        );
    end

    // Status: enabled hits set, written ones clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else
            status_q <= (status_q & ~(wr_status ? bus_wdata[NUM_CH-1:0] : '0))
                      | (hit & ien_q[NUM_CH-1:0]);
    end

    // Interrupt enable keeps only its low IEN_W bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ien_q <= '0;
        else if (wr_ien)
            ien_q <= bus_wdata[IEN_W-1:0];
    end

    // Watchdog arm bit and one-cycle reset request; a match clears the arm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_arm_q <= 1'b0;
            rst_req  <= 1'b0;
        end else begin
            rst_req <= wd_arm_q && hit[WD_CH];
            if (wd_arm_q && hit[WD_CH])
                wd_arm_q <= 1'b0;
            else if (wr_wdog)
                wd_arm_q <= bus_wdata[0];
        end
    end

    // Interrupt lines follow the status bits.
    always_comb irq = status_q;

    // Read mux; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (bus_addr == MT_ADDR_W'(MT_OFF_MATCH0 + 4 * i))
                bus_rdata = match_q[i];
        if (bus_addr == MT_ADDR_W'(MT_OFF_COUNT))  bus_rdata = cnt_q;
        if (bus_addr == MT_ADDR_W'(MT_OFF_STATUS)) bus_rdata = W'(status_q);
        if (bus_addr == MT_ADDR_W'(MT_OFF_WDOG))   bus_rdata = W'(wd_arm_q);
        if (bus_addr == MT_ADDR_W'(MT_OFF_IEN))    bus_rdata = W'(ien_q);
    end
endmodule

// File: rtl/match_timer_chk.sv
// Property checker for match_timer, attached by bind. It observes the
// bus, the counter and the outputs; it drives nothing.
module match_timer_chk
    import match_timer_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick_en,
    input logic [MT_ADDR_W-1:0] bus_addr,
    input logic                 bus_wr,
    input logic [MT_DATA_W-1:0] bus_wdata,
    input logic [MT_DATA_W-1:0] cnt_q,
    input logic                 wd_arm_q,
    input logic [NUM_CH-1:0]    irq,
    input logic                 rst_req
);
    logic load_c;
    always_comb load_c = bus_wr && (bus_addr == MT_ADDR_W'(MT_OFF_COUNT));

    // R2: counter advances by one on a tick without a load.
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !load_c) |=> (cnt_q == $past(cnt_q) + 32'd1));

    // R2: counter holds without tick or load.
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !load_c) |=> $stable(cnt_q));

    // R4: writing all ones to status with no tick drops every line.
    assert_irq_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && bus_wr && bus_addr == MT_ADDR_W'(MT_OFF_STATUS)
         && (&bus_wdata[NUM_CH-1:0])) |=> (irq == '0));

    // R5: an interrupt line can only rise after a tick cycle.
    assert_irq_rise_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~$past(irq)) != '0) |-> $past(tick_en));

    // R7: reset request is a single-cycle pulse.
    assert_rst_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R7: the arm bit is already clear when the request is seen.
    assert_wd_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !wd_arm_q);
endmodule

bind match_timer match_timer_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .cnt_q     (cnt_q),
    .wd_arm_q  (wd_arm_q),
    .irq       (irq),
    .rst_req   (rst_req)
);

// File: tb/match_timer_tb_top.sv
// Self-checking bench: sweeps every channel over several match distances
// and covers wrap, clear, enable, watchdog and unmapped-offset cases.
module match_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;
    logic        rst_req;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;

    always #2 clk = ~clk;   // 250 MHz

    match_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .rst_req(rst_req)
    );

    // Count reset-request cycles, sampled away from the active edge.
    always @(negedge clk) if (rst_req) pulses++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tick(input int k);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (k) @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every register and output.
        for (int a = 0; a < 8'h20; a += 4) begin
            rd(8'(a), v);
            check("R1 reg", v, 32'h0);
        end
        check("R1 irq", {28'h0, irq}, 32'h0);
        check("R1 rst_req", {31'h0, rst_req}, 32'h0);

        // R2: load then count; hold without tick.
        wr(8'h10, 32'h0000_1234);
        tick(7);
        rd(8'h10, v); check("R2 count", v, 32'h0000_123B);
        repeat (5) @(negedge clk);
        rd(8'h10, v); check("R2 hold", v, 32'h0000_123B);

        // R3/R4: sweep each channel over distances 1..4.
        for (int ch = 0; ch < 4; ch++) begin
            wr(8'h1C, 32'(1 << ch));
            for (int d = 1; d <= 4; d++) begin
                base = 32'h1000_0000 * ch + 32'(d * 7);
                wr(8'h10, base);
                wr(8'(4 * ch), base + 32'(d));
                if (d > 1) begin
                    tick(d - 1);
                    check("R3 early", {28'h0, irq}, 32'h0);
                end
                tick(1);
                check("R3 irq", {28'h0, irq}, 32'(1 << ch));
                rd(8'h14, v); check("R3 status", v, 32'(1 << ch));
                wr(8'h14, 32'(1 << ch));
                check("R4 clear", {28'h0, irq}, 32'h0);
                // R5: staying equal does not re-fire.
                repeat (3) @(negedge clk);
                rd(8'h14, v); check("R5 no refire", v, 32'h0);
            end
        end

        // R4: selective clear with two channels hitting together.
        wr(8'h1C, 32'h3);
        wr(8'h10, 32'd200);
        wr(8'h00, 32'd202);
        wr(8'h04, 32'd202);
        tick(2);
        check("R4 both", {28'h0, irq}, 32'h3);
        wr(8'h14, 32'h1);
        check("R4 one cleared", {28'h0, irq}, 32'h2);
        wr(8'h14, 32'h0);
        check("R4 zero write", {28'h0, irq}, 32'h2);
        wr(8'h14, 32'hF);
        check("R4 all cleared", {28'h0, irq}, 32'h0);

        // R5: loading the counter onto the match value does not fire.
        wr(8'h1C, 32'h1);
        wr(8'h00, 32'd500);
        wr(8'h10, 32'd500);
        repeat (2) @(negedge clk);
        rd(8'h14, v); check("R5 load equal", v, 32'h0);
        tick(1);
        rd(8'h14, v); check("R5 step past", v, 32'h0);

        // R3: disabled channel leaves status and irq alone.
        wr(8'h1C, 32'h0);
        wr(8'h10, 32'd700);
        wr(8'h08, 32'd701);
        tick(1);
        rd(8'h14, v); check("R3 disabled status", v, 32'h0);
        check("R3 disabled irq", {28'h0, irq}, 32'h0);

        // R6: only 12 enable bits are kept.
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h1C, v); check("R6 ien width", v, 32'h0000_0FFF);

        // R8: wrap through zero.
        wr(8'h14, 32'hF);
        wr(8'h10, 32'hFFFF_FFFE);
        wr(8'h04, 32'h0000_0001);
        tick(2);
        check("R8 before", {28'h0, irq}, 32'h0);
        tick(1);
        check("R8 wrap irq", {28'h0, irq}, 32'h2);
        rd(8'h10, v); check("R8 count", v, 32'h0000_0001);

        // R7: armed watchdog, interrupts off.
        wr(8'h14, 32'hF);
        wr(8'h1C, 32'h0);
        wr(8'h18, 32'h1);
        rd(8'h18, v); check("R7 armed", v, 32'h1);
        pulses = 0;
        wr(8'h10, 32'd100);
        wr(8'h0C, 32'd103);
        tick(3);
        repeat (3) @(negedge clk);
        check("R7 one pulse", 32'(pulses), 32'd1);
        rd(8'h18, v); check("R7 disarmed", v, 32'h0);
        check("R7 irq off", {28'h0, irq}, 32'h0);
        // R7: only bit 0 arms.
        wr(8'h18, 32'h2);
        rd(8'h18, v); check("R7 bit0 only", v, 32'h0);
        wr(8'h10, 32'd100);
        tick(3);
        repeat (3) @(negedge clk);
        check("R7 unarmed", 32'(pulses), 32'd1);

        // R9: unmapped offsets.
        wr(8'h1C, 32'h5);
        wr(8'h20, 32'hDEAD_BEEF);
        rd(8'h20, v); check("R9 read 20", v, 32'h0);
        rd(8'h44, v); check("R9 read 44", v, 32'h0);
        rd(8'h1C, v); check("R9 ien kept", v, 32'h5);
        rd(8'h0C, v); check("R9 match kept", v, 32'd103);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule